// File: doc/BRIEF.md
# Nibble-Packed Pixel RAM Write Port

This block fronts a word-wide RAM in which every 16-bit word stores four 4-bit pixels. Each pixel has its own byte address: the address bits above bit 1 pick the RAM word, and bits 1:0 pick the nibble lane inside it. Lane 0 is bits 15:12 and lane 3 is bits 3:0. A CPU-style requester drives a read or write strobe, a byte or word size select, a byte address, write data and a 2-bit priority mode. Writes change single nibbles. Reads return pixels in a packed format: each pixel sits in the low half of its own byte.

The priority mode decides whether a nibble write lands. In plain mode every write lands. In overwrite mode a zero pixel counts as transparent and is dropped. In underwrite mode a pixel lands only on a lane that still holds zero, and only when the pixel itself is non-zero. Underwrite needs the old word first, so the port spends one extra RAM cycle on it and reports busy during that cycle. A word write places two pixels into the two lanes of the addressed pair, and the rule is applied to each of them on its own.

The control is a three-state machine. ST_IDLE accepts requests. ST_UW_COMMIT is entered from ST_IDLE on an underwrite write; it merges the fetched word and returns to ST_IDLE. ST_RD_RETURN is entered from ST_IDLE on a read; it presents the read data and returns to ST_IDLE. Plain and overwrite writes complete in ST_IDLE with no transition.

Top module: `pix_nibble_port`

## Requirements
- R1: The RAM word is addressed by `addr[ADDR_W-1:2]`, and `addr[1:0]` selects the nibble lane: 0 is bits 15:12, 1 is bits 11:8, 2 is bits 7:4 and 3 is bits 3:0. Every word of the RAM is reachable, including the last one.
- R2: A byte write (`size_word`=0) stores only `wdata[3:0]` into the selected lane. `wdata[15:4]` has no effect.
- R3: With `prio_mode` 2'b00 (plain), or the illegal value 2'b11, a write always lands, a zero value included. It completes without raising `busy`.
- R4: With `prio_mode` 2'b10 (overwrite), a nibble write whose value is zero is discarded, and a non-zero value is stored.
- R5: With `prio_mode` 2'b01 (underwrite), a nibble is stored only when the new value is non-zero and the stored nibble is zero.
- R6: An underwrite write accepted in a cycle raises `busy` for exactly the following cycle. Any request presented while `busy` is high is ignored.
- R7: A read request accepted while `busy` is low gives `rvalid`=1 in the next cycle, and `busy` is high in that cycle. A word read returns `{4'h0, lane A, 4'h0, lane B}`, where lanes A and B are lanes 0 and 1 when `addr[1]`=0 and lanes 2 and 3 when `addr[1]`=1. `addr[0]` is ignored.
- R8: A byte read returns the packed word's bits 15:8 for an even address and its bits 7:0 for an odd address. The result is placed in `rdata[7:0]`, and `rdata[15:8]` is zero.
- R9: A word write stores `wdata[11:8]` into lane {addr[1],0} and `wdata[3:0]` into lane {addr[1],1}. Each nibble follows the priority rule on its own. `addr[0]` and the other data bits are ignored.
- R10: When `req_rd` and `req_wr` are both high, only the write is performed, and `rvalid` stays low.
- R11: After reset, `busy` and `rvalid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_rd | input | 1 | Read strobe |
| req_wr | input | 1 | Write strobe |
| size_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| addr | input | ADDR_W | Byte (pixel) address |
| wdata | input | 16 | Write data |
| prio_mode | input | 2 | Bit 1 = overwrite, bit 0 = underwrite |
| busy | output | 1 | Port not accepting requests this cycle |
| rvalid | output | 1 | Read data valid |
| rdata | output | 16 | Packed read data, zero when `rvalid` is low |

## Verification
Nibble writes are driven in all four priority modes. Zero and non-zero values are used against both zero and non-zero stored nibbles, so that plain, overwrite and underwrite decisions each give a different result. Word accesses are made at even and odd addresses on both lane pairs. This separates correct lane steering from swapped or shifted lanes and shows that `addr[0]` is ignored. Byte reads at each lane position confirm the half of the packed word that is selected. Directed cases cover a write presented during the underwrite busy cycle, simultaneous read and write strobes, and the last word of the RAM.

// File: rtl/nibport_pkg.sv
package nibport_pkg;

    localparam int NIB_W   = 4;
    localparam int LANES   = 4;
    localparam int WORD_W  = NIB_W * LANES;

    localparam logic [1:0] MODE_PLAIN = 2'b00;
    localparam logic [1:0] MODE_UNDER = 2'b01;
    localparam logic [1:0] MODE_OVER  = 2'b10;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_UW_COMMIT = 2'd1,
        ST_RD_RETURN = 2'd2
    } port_state_e;

    // Nibble of lane 'lane' (lane 0 = most significant nibble)
    function automatic logic [NIB_W-1:0] lane_nib(input logic [WORD_W-1:0] w,
                                                 input logic [1:0] lane);
        return w[(WORD_W - 1 - NIB_W * int'(lane)) -: NIB_W];
    endfunction

endpackage

// File: rtl/nib_ram.sv
module nib_ram
    import nibport_pkg::*;
#(
    parameter int WORD_AW = 8
) (
    input  logic                 clk,
    input  logic                 en,
    input  logic [LANES-1:0]     we_lane,
    input  logic [WORD_AW-1:0]   addr,
    input  logic [WORD_W-1:0]    wdata,
    output logic [WORD_W-1:0]    rdata
);
    localparam int DEPTH = 1 << WORD_AW;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int HI = WORD_W - 1 - NIB_W * g;
        logic [NIB_W-1:0] mem [DEPTH];
        logic [NIB_W-1:0] q;

        always_ff @(posedge clk) begin
            if (en) begin
                if (we_lane[g]) begin
                    mem[addr] <= wdata[HI -: NIB_W];
                end
                q <= mem[addr];
            end
        end

        assign rdata[HI -: NIB_W] = q;
    end

endmodule

// File: rtl/nib_lane_steer.sv
module nib_lane_steer
    import nibport_pkg::*;
(
    input  logic [1:0]         lane_addr,
    input  logic               size_word,
    input  logic [WORD_W-1:0]  wdata,
    output logic [LANES-1:0]   lane_sel,
    output logic [WORD_W-1:0]  lane_data
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int HI = WORD_W - 1 - NIB_W * g;
        localparam logic [1:0] LID = 2'(g);

        always_comb begin
            if (size_word) begin
                // pair selected by address bit 1; even lane takes the high byte
                lane_sel[g] = (LID[1] == lane_addr[1]);
                lane_data[HI -: NIB_W] = LID[0] ? wdata[3:0] : wdata[11:8];
            end else begin
                lane_sel[g] = (LID == lane_addr);
                lane_data[HI -: NIB_W] = wdata[3:0];
            end
        end
    end
endmodule

// File: rtl/nib_prio_eval.sv
module nib_prio_eval
    import nibport_pkg::*;
(
    input  logic [1:0]         mode,
    input  logic [LANES-1:0]   lane_sel,
    input  logic [WORD_W-1:0]  new_word,
    input  logic [WORD_W-1:0]  old_word,
    output logic [LANES-1:0]   lane_we
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int HI = WORD_W - 1 - NIB_W * g;
        logic nz_new;
        logic z_old;

        assign nz_new = |new_word[HI -: NIB_W];
        assign z_old  = ~|old_word[HI -: NIB_W];

        always_comb begin
            unique case (mode)
                MODE_OVER:  lane_we[g] = lane_sel[g] & nz_new;
                MODE_UNDER: lane_we[g] = lane_sel[g] & nz_new & z_old;
                default:    lane_we[g] = lane_sel[g];
            endcase
        end
    end
endmodule

// File: rtl/nib_read_pack.sv
module nib_read_pack
    import nibport_pkg::*;
(
    input  logic [WORD_W-1:0]  word,
    input  logic [1:0]         lane_addr,
    input  logic               size_word,
    output logic [WORD_W-1:0]  packed_out
);
    logic [NIB_W-1:0] pix_even;
    logic [NIB_W-1:0] pix_odd;
    logic [WORD_W-1:0] pair;

    always_comb begin
        pix_even = lane_nib(word, {lane_addr[1], 1'b0});
        pix_odd  = lane_nib(word, {lane_addr[1], 1'b1});
        pair     = {4'h0, pix_even, 4'h0, pix_odd};
        if (size_word) begin
            packed_out = pair;
        end else if (lane_addr[0]) begin
            packed_out = {8'h00, pair[7:0]};
        end else begin
            packed_out = {8'h00, pair[15:8]};
        end
    end
endmodule

// File: rtl/pix_nibble_port.sv
module pix_nibble_port
    import nibport_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_rd,
    input  logic              req_wr,
    input  logic              size_word,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       wdata,
    input  logic [1:0]        prio_mode,
    output logic              busy,
    output logic              rvalid,
    output logic [15:0]       rdata
);
    localparam int WORD_AW = ADDR_W - 2;

    port_state_e state_q, state_d;

    logic wr_go, rd_go, is_under;

    logic [LANES-1:0]   cur_sel;
    logic [WORD_W-1:0]  cur_data;

    logic [WORD_AW-1:0] lat_word;
    logic [LANES-1:0]   lat_sel;
    logic [WORD_W-1:0]  lat_data;
    logic [1:0]         lat_mode;
    logic [1:0]         lat_lane;
    logic               lat_size;

    logic [1:0]         ev_mode;
    logic [LANES-1:0]   ev_sel;
    logic [LANES-1:0]   ev_we;

    logic               ram_en;
    logic [LANES-1:0]   ram_we;
    logic [WORD_AW-1:0] ram_addr;
    logic [WORD_W-1:0]  ram_wdata;
    logic [WORD_W-1:0]  ram_rdata;
    logic [WORD_W-1:0]  packed_rd;

    assign is_under = (prio_mode == MODE_UNDER);
    assign wr_go    = (state_q == ST_IDLE) && req_wr;
    assign rd_go    = (state_q == ST_IDLE) && req_rd && !req_wr;

    nib_lane_steer u_steer (
        .lane_addr (addr[1:0]),
        .size_word (size_word),
        .wdata     (wdata),
        .lane_sel  (cur_sel),
        .lane_data (cur_data)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (wr_go && is_under) begin
                    state_d = ST_UW_COMMIT;
                end else if (rd_go) begin
                    state_d = ST_RD_RETURN;
                end
            end
            ST_UW_COMMIT: state_d = ST_IDLE;
            ST_RD_RETURN: state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // Request capture for the second cycle of underwrite and read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_word <= '0;
            lat_sel  <= '0;
            lat_data <= '0;
            lat_mode <= MODE_PLAIN;
            lat_lane <= '0;
            lat_size <= 1'b0;
        end else if (wr_go || rd_go) begin
            lat_word <= addr[ADDR_W-1:2];
            lat_sel  <= cur_sel;
            lat_data <= cur_data;
            lat_mode <= prio_mode;
            lat_lane <= addr[1:0];
            lat_size <= size_word;
        end
    end

    assign ev_mode = (state_q == ST_UW_COMMIT) ? lat_mode : prio_mode;
    assign ev_sel  = (state_q == ST_UW_COMMIT) ? lat_sel  : cur_sel;

    nib_prio_eval u_eval (
        .mode     (ev_mode),
        .lane_sel (ev_sel),
        .new_word (ram_wdata),
        .old_word (ram_rdata),
        .lane_we  (ev_we)
    );

    // Outputs and RAM controls
    always_comb begin
        ram_en    = 1'b0;
        ram_we    = '0;
        ram_addr  = lat_word;
        ram_wdata = cur_data;
        busy      = 1'b1;
        rvalid    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy     = 1'b0;
                ram_addr = addr[ADDR_W-1:2];
                ram_en   = wr_go || rd_go;
                if (wr_go && !is_under) begin
                    ram_we = ev_we;
                end
            end
            ST_UW_COMMIT: begin
                ram_en    = 1'b1;
                ram_wdata = lat_data;
                ram_we    = ev_we;
            end
            ST_RD_RETURN: begin
                rvalid = 1'b1;
            end
            default: begin
                busy = 1'b1;
            end
        endcase
    end

    nib_ram #(.WORD_AW(WORD_AW)) u_ram (
        .clk     (clk),
        .en      (ram_en),
        .we_lane (ram_we),
        .addr    (ram_addr),
        .wdata   (ram_wdata),
        .rdata   (ram_rdata)
    );

    nib_read_pack u_pack (
        .word       (ram_rdata),
        .lane_addr  (lat_lane),
        .size_word  (lat_size),
        .packed_out (packed_rd)
    );

    assign rdata = rvalid ? packed_rd : 16'h0000;

endmodule

// File: rtl/nibport_chk.sv
module nibport_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_rd,
    input logic        req_wr,
    input logic [1:0]  prio_mode,
    input logic        busy,
    input logic        rvalid,
    input logic [15:0] rdata,
    input logic [3:0]  ram_we,
    input logic [15:0] ram_wdata,
    input logic [15:0] ram_rdata
);
    assert_uw_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_wr && prio_mode == 2'b01) |=> (busy && !rvalid));

    assert_busy_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);

    assert_uw_no_early_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_wr && prio_mode == 2'b01) |-> (ram_we == 4'b0000));

    assert_read_return_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_rd && !req_wr) |=> rvalid);

    assert_write_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_wr) |=> !rvalid);

    assert_packed_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> (rdata[15:12] == 4'h0 && rdata[7:4] == 4'h0));

    assert_over_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && prio_mode == 2'b10) |->
            ((!ram_we[0] || ram_wdata[15:12] != 4'h0) &&
             (!ram_we[1] || ram_wdata[11:8]  != 4'h0) &&
             (!ram_we[2] || ram_wdata[7:4]   != 4'h0) &&
             (!ram_we[3] || ram_wdata[3:0]   != 4'h0)));

    assert_under_rule_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !rvalid) |->
            ((!ram_we[0] || (ram_wdata[15:12] != 4'h0 && ram_rdata[15:12] == 4'h0)) &&
             (!ram_we[1] || (ram_wdata[11:8]  != 4'h0 && ram_rdata[11:8]  == 4'h0)) &&
             (!ram_we[2] || (ram_wdata[7:4]   != 4'h0 && ram_rdata[7:4]   == 4'h0)) &&
             (!ram_we[3] || (ram_wdata[3:0]   != 4'h0 && ram_rdata[3:0]   == 4'h0))));
endmodule

bind pix_nibble_port nibport_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_rd    (req_rd),
    .req_wr    (req_wr),
    .prio_mode (prio_mode),
    .busy      (busy),
    .rvalid    (rvalid),
    .rdata     (rdata),
    .ram_we    (ram_we),
    .ram_wdata (ram_wdata),
    .ram_rdata (ram_rdata)
);

// File: tb/tb_pix_nibble_port.sv
`timescale 1ns/1ps
module tb_pix_nibble_port;
    localparam int AW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_rd = 1'b0;
    logic          req_wr = 1'b0;
    logic          size_word = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [15:0]   wdata = '0;
    logic [1:0]    prio_mode = 2'b00;
    logic          busy;
    logic          rvalid;
    logic [15:0]   rdata;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    pix_nibble_port #(.ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .req_rd(req_rd), .req_wr(req_wr),
        .size_word(size_word), .addr(addr), .wdata(wdata),
        .prio_mode(prio_mode), .busy(busy), .rvalid(rvalid), .rdata(rdata)
    );

    typedef struct packed {
        logic          rd;
        logic          wsz;
        logic [AW-1:0] a;
        logic [15:0]   d;
        logic [1:0]    m;
        logic [15:0]   e;
        logic [3:0]    rq;
    } vec_t;

    localparam int NV = 36;
    // Modes: 00 plain, 10 overwrite, 01 underwrite, 11 illegal (plain)
    localparam vec_t VT [NV] = '{
        '{1'b0, 1'b1, 10'h000, 16'h0A0B, 2'b00, 16'h0000, 4'd9},  // R9 lanes 0,1
        '{1'b0, 1'b1, 10'h002, 16'h0C0D, 2'b00, 16'h0000, 4'd9},  // R9 lanes 2,3
        '{1'b1, 1'b1, 10'h000, 16'h0000, 2'b00, 16'h0A0B, 4'd7},  // R7 pair 0
        '{1'b1, 1'b1, 10'h003, 16'h0000, 2'b00, 16'h0C0D, 4'd7},  // R7 pair 1, odd addr
        '{1'b1, 1'b0, 10'h000, 16'h0000, 2'b00, 16'h000A, 4'd8},  // R8 even byte
        '{1'b1, 1'b0, 10'h003, 16'h0000, 2'b00, 16'h000D, 4'd8},  // R8 odd byte
        '{1'b0, 1'b0, 10'h001, 16'hFFF5, 2'b00, 16'h0000, 4'd2},  // R2 upper bits ignored
        '{1'b1, 1'b0, 10'h001, 16'h0000, 2'b00, 16'h0005, 4'd2},
        '{1'b0, 1'b0, 10'h002, 16'h0000, 2'b10, 16'h0000, 4'd4},  // R4 zero dropped
        '{1'b1, 1'b0, 10'h002, 16'h0000, 2'b00, 16'h000C, 4'd4},
        '{1'b0, 1'b0, 10'h002, 16'h0007, 2'b10, 16'h0000, 4'd4},  // R4 non-zero stored
        '{1'b1, 1'b1, 10'h002, 16'h0000, 2'b00, 16'h070D, 4'd4},
        '{1'b0, 1'b0, 10'h000, 16'h0000, 2'b00, 16'h0000, 4'd3},  // R3 plain zero lands
        '{1'b1, 1'b0, 10'h000, 16'h0000, 2'b00, 16'h0000, 4'd3},
        '{1'b0, 1'b0, 10'h000, 16'h0003, 2'b01, 16'h0000, 4'd5},  // R5 onto zero
        '{1'b1, 1'b0, 10'h000, 16'h0000, 2'b00, 16'h0003, 4'd5},
        '{1'b0, 1'b0, 10'h000, 16'h0009, 2'b01, 16'h0000, 4'd5},  // R5 onto non-zero
        '{1'b1, 1'b0, 10'h000, 16'h0000, 2'b00, 16'h0003, 4'd5},
        '{1'b0, 1'b0, 10'h003, 16'h0000, 2'b11, 16'h0000, 4'd3},  // R3 illegal mode plain
        '{1'b1, 1'b0, 10'h003, 16'h0000, 2'b00, 16'h0000, 4'd3},
        '{1'b0, 1'b1, 10'h004, 16'h0000, 2'b00, 16'h0000, 4'd9},
        '{1'b0, 1'b1, 10'h006, 16'h0E00, 2'b00, 16'h0000, 4'd9},
        '{1'b0, 1'b1, 10'h004, 16'h0102, 2'b01, 16'h0000, 4'd5},  // R5 word both land
        '{1'b1, 1'b1, 10'h004, 16'h0000, 2'b00, 16'h0102, 4'd5},
        '{1'b0, 1'b1, 10'h006, 16'h0403, 2'b01, 16'h0000, 4'd5},  // R5 one of two lands
        '{1'b1, 1'b1, 10'h006, 16'h0000, 2'b00, 16'h0E03, 4'd5},
        '{1'b0, 1'b1, 10'h004, 16'h0600, 2'b10, 16'h0000, 4'd9},  // R9 per-nibble overwrite
        '{1'b1, 1'b1, 10'h004, 16'h0000, 2'b00, 16'h0602, 4'd9},
        '{1'b0, 1'b1, 10'h005, 16'h0807, 2'b00, 16'h0000, 4'd9},  // R9 odd word address
        '{1'b1, 1'b1, 10'h004, 16'h0000, 2'b00, 16'h0807, 4'd9},
        '{1'b0, 1'b1, 10'h008, 16'hF3F4, 2'b00, 16'h0000, 4'd9},  // R9 other bits ignored
        '{1'b1, 1'b1, 10'h008, 16'h0000, 2'b00, 16'h0304, 4'd9},
        '{1'b0, 1'b0, 10'h3FF, 16'h000A, 2'b00, 16'h0000, 4'd1},  // R1 last word
        '{1'b1, 1'b0, 10'h3FF, 16'h0000, 2'b00, 16'h000A, 4'd1},
        '{1'b1, 1'b1, 10'h000, 16'h0000, 2'b00, 16'h0305, 4'd1},  // R1 lane map
        '{1'b1, 1'b1, 10'h002, 16'h0000, 2'b00, 16'h0700, 4'd1}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic sz, input logic [AW-1:0] a,
                            input logic [15:0] d, input logic [1:0] m);
        @(negedge clk);
        req_wr = 1'b1; size_word = sz; addr = a; wdata = d; prio_mode = m;
        @(negedge clk);
        req_wr = 1'b0;
        while (busy) @(negedge clk);
    endtask

    task automatic do_read(input logic sz, input logic [AW-1:0] a,
                           output logic [15:0] d, output logic v);
        @(negedge clk);
        req_rd = 1'b1; size_word = sz; addr = a; prio_mode = 2'b00;
        @(negedge clk);
        req_rd = 1'b0;
        d = rdata;
        v = rvalid;
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] got;
        logic        v;

        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11 busy", {15'd0, busy}, 16'd0);
        chk("R11 rvalid", {15'd0, rvalid}, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            if (VT[i].rd) begin
                do_read(VT[i].wsz, VT[i].a, got, v);
                chk($sformatf("R%0d vector %0d", VT[i].rq, i), got, VT[i].e);
                if (!v) chk($sformatf("R7 rvalid vector %0d", i), {15'd0, v}, 16'd1);
            end else begin
                do_write(VT[i].wsz, VT[i].a, VT[i].d, VT[i].m);
            end
        end

        // R3: plain write never raises busy
        @(negedge clk);
        req_wr = 1'b1; size_word = 1'b0; addr = 10'h010; wdata = 16'h0001; prio_mode = 2'b00;
        @(negedge clk);
        req_wr = 1'b0;
        chk("R3 no busy", {15'd0, busy}, 16'd0);

        // R6: busy for one cycle, request during busy ignored
        do_write(1'b1, 10'h00C, 16'h0000, 2'b00);
        @(negedge clk);
        req_wr = 1'b1; size_word = 1'b0; addr = 10'h00C; wdata = 16'h0005; prio_mode = 2'b01;
        @(negedge clk);
        chk("R6 busy raised", {15'd0, busy}, 16'd1);
        addr = 10'h00D; wdata = 16'h0009; prio_mode = 2'b00;
        @(negedge clk);
        req_wr = 1'b0;
        chk("R6 busy dropped", {15'd0, busy}, 16'd0);
        do_read(1'b1, 10'h00C, got, v);
        chk("R6 ignored write", got, 16'h0500);

        // R7: busy during read return
        @(negedge clk);
        req_rd = 1'b1; size_word = 1'b1; addr = 10'h00C;
        @(negedge clk);
        req_rd = 1'b0;
        chk("R7 busy on return", {15'd0, busy}, 16'd1);
        chk("R7 rvalid", {15'd0, rvalid}, 16'd1);
        @(negedge clk);
        chk("R7 rdata zero when idle", rdata, 16'h0000);

        // R10: read and write together
        do_write(1'b1, 10'h014, 16'h0101, 2'b00);
        @(negedge clk);
        req_rd = 1'b1; req_wr = 1'b1; size_word = 1'b0; addr = 10'h014;
        wdata = 16'h0004; prio_mode = 2'b00;
        @(negedge clk);
        req_rd = 1'b0; req_wr = 1'b0;
        chk("R10 no rvalid", {15'd0, rvalid}, 16'd0);
        do_read(1'b1, 10'h014, got, v);
        chk("R10 write done", got, 16'h0401);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule